// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Compare Reset

This block is a 16-bit up-counter reached through a byte-wide register port. Software picks the count source: either a one-cycle internal tick at the instruction rate, or an external clock pin that is brought into the system clock domain before it is used. Ahead of the counter sits a prescaler that divides by 1, 2, 4 or 8. When the count wraps past its top value, an overflow flag is set and stays set. That flag, ANDed with an enable bit, drives the interrupt request.

A compare register can turn the counter into a periodic event source. When the special-event mode code is loaded and a counter step starts from the compare value, the counter returns to zero rather than stepping on. The block also emits a one-cycle pulse that a converter can use as its start signal. The compare value then acts as the period: there are compare+1 counter steps per cycle. A special-event clear never sets the overflow flag. A software write to a count byte overrides the clear.

Top module: `evt_timer16`

## Requirements
- R1: Register addresses are: 0 control, 1 count low byte, 2 count high byte, 3 compare low byte, 4 compare high byte, 5 mode (bits 3:0), 6 flag (bit 0), 7 enable (bit 0). Unused read bits return 0. Reads are combinational from the address, and a write takes effect at the clock edge where `we_i` is high.
- R2: Each counter step adds one, and a step from 0xFFFF yields 0x0000.
- R3: A step from 0xFFFF to 0x0000 sets the overflow flag. `irq_o` is that flag ANDed with the enable bit.
- R4: The flag keeps its value until software writes it. If a write of 0 and an overflow fall on the same edge, the flag ends up 1.
- R5: Control fields are bit 0 run, bit 1 source (1 = external pin), bit 2 unsynchronized-mode select, bit 3 oscillator enable (stored only), and bits 5:4 prescale select. Bits 7:6 read 0. Every field resets to 0. While run is 0, the count holds.
- R6: With source 0, each cycle with `tick_i` high is a count event. With source 1, a rising edge on `ext_clk_i` is a count event. A high level on `ext_clk_i` that is first sampled at edge k produces its step at edge k+2.
- R7: Prescale select 0, 1, 2 and 3 makes one counter step per 1, 2, 4 and 8 count events. Any write to a count byte clears the prescaler's progress.
- R8: When the mode is 0xB and a step would start from a count equal to the compare value, the count becomes 0. In the following cycle, `conv_start_o` is high for one cycle.
- R9: A special-event clear, including one with compare value 0xFFFF, leaves the overflow flag unchanged.
- R10: A count-byte write on the same edge as a special-event clear loads the written byte. The other byte keeps its value, and no converter pulse is issued.
- R11: The special-event clear is disabled when source is 1 and bit 2 is 1 at the same time. The counter then steps past the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal instruction-rate count tick |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt request |
| conv_start_o | output | 1 | One-cycle converter start pulse |

## Verification
Register writes and internal ticks show up in the read data and in `irq_o` one edge after they are applied. An external rising edge reaches the count two edges after it is first sampled. The converter pulse appears in the cycle after the clearing edge. The bench drives its inputs just after the falling edge. Its cycle model advances on the same rising edge as the design, and it compares a little after the next falling edge. Every output is therefore checked in the exact cycle its result is due. Directed checks confirm these latencies, including the two-edge external delay.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  typedef enum logic [2:0] {
    A_CTL  = 3'd0,
    A_CNTL = 3'd1,
    A_CNTH = 3'd2,
    A_CMPL = 3'd3,
    A_CMPH = 3'd4,
    A_MODE = 3'd5,
    A_FLAG = 3'd6,
    A_EN   = 3'd7
  } reg_addr_e;

  localparam logic [3:0] MODE_SEV = 4'b1011;

  // control bit positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_SRC  = 1;
  localparam int unsigned C_NSYN = 2;
  localparam int unsigned C_OSC  = 3;
  localparam int unsigned C_PS   = 4;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r6_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int unsigned PW = (2 ** SEL_W) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  assign mask   = ~({PW{1'b1}} << sel_i);
  assign step_o = event_i && ((pre_q | ~mask) == {PW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (event_i) pre_q <= step_o ? '0 : pre_q + 1'b1;
  end

  a_r7_clear_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/evt_count.sv
module evt_count #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CW-1:0]     cmp_i,
  input  logic              sev_en_i,
  output logic [CW-1:0]     cnt_o,
  output logic              ovf_o,
  output logic              sev_o
);
  logic [CW-1:0] cnt_q;
  logic          sev_q;
  logic          wr;
  logic          hit;

  assign wr    = wr_lo_i | wr_hi_i;
  assign hit   = sev_en_i && step_i && (cnt_q == cmp_i);
  assign ovf_o = step_i && !wr && !hit && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sev_q <= 1'b0;
    end else if (wr) begin
      if (wr_lo_i) cnt_q[DATA_W-1:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[CW-1:DATA_W] <= wdata_i;
      sev_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      sev_q <= 1'b1;
    end else begin
      sev_q <= 1'b0;
      if (step_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign sev_o = sev_q;

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr && !sev_en_i && (&cnt_q)) |=> (cnt_q == '0));
  a_r8_sev_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sev_q |-> (cnt_q == '0));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (cnt_q[DATA_W-1:0] == $past(wdata_i)) && !sev_q);
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PS_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              conv_start_o
);
  localparam int unsigned CW    = 2 * DATA_W;
  localparam int unsigned CTL_W = C_PS + PS_W;
  localparam int unsigned MW    = 4;

  logic [CTL_W-1:0] ctl_q;
  logic [CW-1:0]    cmp_q;
  logic [MW-1:0]    mode_q;
  logic             flag_q;
  logic             en_q;

  logic ext_rise, cnt_event, step, ovf, sev, sev_en;
  logic wr_lo, wr_hi, flag_wr;
  logic [CW-1:0] cnt;
  reg_addr_e addr;

  assign addr    = reg_addr_e'(addr_i);
  assign wr_lo   = we_i && (addr == A_CNTL);
  assign wr_hi   = we_i && (addr == A_CNTH);
  assign flag_wr = we_i && (addr == A_FLAG);

  assign cnt_event = ctl_q[C_RUN] && (ctl_q[C_SRC] ? ext_rise : tick_i);
  assign sev_en    = (mode_q == MODE_SEV) && !(ctl_q[C_SRC] && ctl_q[C_NSYN]);

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_clk_i), .rise_o(ext_rise)
  );

  evt_prescale #(.SEL_W(PS_W)) u_pre (
    .clk_i, .rst_ni, .event_i(cnt_event), .clr_i(wr_lo | wr_hi),
    .sel_i(ctl_q[C_PS +: PS_W]), .step_o(step)
  );

  evt_count #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i, .cmp_i(cmp_q), .sev_en_i(sev_en),
    .cnt_o(cnt), .ovf_o(ovf), .sev_o(sev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      cmp_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i) begin
      unique case (addr)
        A_CTL:  ctl_q               <= wdata_i[CTL_W-1:0];
        A_CMPL: cmp_q[DATA_W-1:0]   <= wdata_i;
        A_CMPH: cmp_q[CW-1:DATA_W]  <= wdata_i;
        A_MODE: mode_q              <= wdata_i[MW-1:0];
        A_EN:   en_q                <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // overflow set beats a software clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_wr) flag_q <= wdata_i[0] | ovf;
    else if (ovf)     flag_q <= 1'b1;
  end

  always_comb begin
    unique case (addr)
      A_CTL:   rdata_o = DATA_W'(ctl_q);
      A_CNTL:  rdata_o = cnt[DATA_W-1:0];
      A_CNTH:  rdata_o = cnt[CW-1:DATA_W];
      A_CMPL:  rdata_o = cmp_q[DATA_W-1:0];
      A_CMPH:  rdata_o = cmp_q[CW-1:DATA_W];
      A_MODE:  rdata_o = DATA_W'(mode_q);
      A_FLAG:  rdata_o = DATA_W'(flag_q);
      default: rdata_o = DATA_W'(en_q);
    endcase
  end

  assign irq_o        = flag_q & en_q;
  assign conv_start_o = sev;

  a_r3_ovf_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> flag_q);
  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_wr) |=> flag_q);
  a_r5_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[C_RUN] && !wr_lo && !wr_hi) |=> (cnt == $past(cnt)));
  a_r9_sev_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sev && !$past(flag_wr)) |-> (flag_q == $past(flag_q)));
  a_r11_sev_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sev |-> !($past(ctl_q[C_SRC]) && $past(ctl_q[C_NSYN])));
endmodule

// File: tb/evt_timer16_bench.sv
`timescale 1ns/1ps
module evt_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, conv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer16 u_evt_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_clk_i(ext),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .conv_start_o(conv)
  );

  // reference model, built from the requirements
  logic [5:0]  m_ctl;
  logic [15:0] m_cnt, m_cmp;
  logic [3:0]  m_mode;
  logic        m_flag, m_en, m_conv;
  logic [2:0]  m_pre;
  logic [2:0]  m_sh;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_ctl};
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_cmp[7:0];
      3'd4: return m_cmp[15:8];
      3'd5: return {4'b0, m_mode};
      3'd6: return {7'b0, m_flag};
      default: return {7'b0, m_en};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1, 3'd2: return "R2";
      3'd6: return "R4";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_cnt = '0; m_cmp = '0; m_mode = '0;
      m_flag = 0; m_en = 0; m_conv = 0; m_pre = '0; m_sh = '0;
    end else begin
      logic ev, st, hit, ovf, wlo, whi;
      logic [2:0] mask;
      ev   = m_ctl[0] && (m_ctl[1] ? (m_sh[1] && !m_sh[2]) : tick);
      mask = 3'((1 << m_ctl[5:4]) - 1);
      st   = ev && ((m_pre & mask) == mask);
      wlo  = we && addr == 3'd1;
      whi  = we && addr == 3'd2;
      hit  = st && m_mode == 4'hB && !(m_ctl[1] && m_ctl[2]) && m_cnt == m_cmp;
      ovf  = 0;
      m_sh = {m_sh[1:0], ext};
      if (wlo || whi) m_pre = 0;
      else if (ev) m_pre = st ? 3'd0 : m_pre + 1;
      if (wlo || whi) begin
        if (wlo) m_cnt[7:0] = wdata;
        if (whi) m_cnt[15:8] = wdata;
        m_conv = 0;
      end else if (hit) begin
        m_cnt = 0; m_conv = 1;
      end else begin
        m_conv = 0;
        if (st) begin ovf = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
      end
      if (we && addr == 3'd6) m_flag = wdata[0] | ovf;
      else if (ovf) m_flag = 1;
      if (we) case (addr)
        3'd0: m_ctl = wdata[5:0];
        3'd3: m_cmp[7:0] = wdata;
        3'd4: m_cmp[15:8] = wdata;
        3'd5: m_mode = wdata[3:0];
        3'd7: m_en = wdata[0];
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive after negedge, compare state produced by the previous rising edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d,
                     input logic t, input logic e);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t; ext = e;
    #1;
    chk(tag_of(a), {8'h0, rdata}, {8'h0, m_read(a)});
    chk("R3", {15'h0, irq}, {15'h0, m_flag & m_en});
    chk("R8", {15'h0, conv}, {15'h0, m_conv});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, ext);
  endtask

  task automatic rd(input logic [2:0] a, input logic t);
    cyc(0, a, 8'h00, t, ext);
  endtask

  task automatic cnt_is(input string req, input logic [15:0] exp);
    rd(3'd2, 0);
    chk(req, {8'h0, rdata}, {8'h0, exp[15:8]});
    rd(3'd1, 0);
    chk(req, {8'h0, rdata}, {8'h0, exp[7:0]});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state and map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), 0);
      chk((a == 0) ? "R5" : "R1", {8'h0, rdata}, 16'h0);
    end
    wr(3'd0, 8'hFF);
    rd(3'd0, 0); chk("R5", {8'h0, rdata}, 16'h003F);

    // wrap and overflow flag
    wr(3'd0, 8'h01); wr(3'd7, 8'h01);
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFE);
    rd(3'd1, 1); rd(3'd1, 1);
    cnt_is("R2", 16'h0000);
    rd(3'd6, 0); chk("R3", {8'h0, rdata}, 16'h1);
    chk("R3", {15'h0, irq}, 16'h1);
    rd(3'd6, 0); chk("R4", {8'h0, rdata}, 16'h1);

    // clear, then clear colliding with overflow
    wr(3'd6, 8'h00); rd(3'd6, 0); chk("R4", {8'h0, rdata}, 16'h0);
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
    cyc(1, 3'd6, 8'h00, 1, 0);
    rd(3'd6, 0); chk("R4", {8'h0, rdata}, 16'h1);
    wr(3'd6, 8'h00);

    // hold while stopped
    wr(3'd0, 8'h00); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
    repeat (6) rd(3'd1, 1);
    cnt_is("R5", 16'h1234);

    // prescale 1:8
    wr(3'd0, 8'h31); wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    repeat (16) rd(3'd1, 1);
    cnt_is("R7", 16'h0002);
    wr(3'd0, 8'h11); wr(3'd1, 8'h00);
    repeat (5) rd(3'd1, 1);
    cnt_is("R7", 16'h0002);

    // special event with period 6
    wr(3'd0, 8'h01); wr(3'd5, 8'h0B); wr(3'd3, 8'h05); wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);
    repeat (6) rd(3'd1, 1);
    rd(3'd1, 0);
    chk("R8", {15'h0, conv}, 16'h1);
    chk("R8", {8'h0, rdata}, 16'h0);
    rd(3'd1, 0); chk("R8", {15'h0, conv}, 16'h0);

    // special event at 0xFFFF leaves flag alone
    wr(3'd4, 8'hFF); wr(3'd3, 8'hFF); wr(3'd6, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFE);
    rd(3'd6, 1); rd(3'd6, 1);
    rd(3'd6, 0);
    chk("R9", {8'h0, rdata}, 16'h0);
    cnt_is("R9", 16'h0000);

    // write beats special-event clear
    wr(3'd4, 8'h00); wr(3'd3, 8'h05); wr(3'd2, 8'h00); wr(3'd1, 8'h05);
    cyc(1, 3'd1, 8'h42, 1, 0);
    rd(3'd1, 0); chk("R10", {15'h0, conv}, 16'h0);
    cnt_is("R10", 16'h0042);

    // external source: latency, then gating of the clear
    wr(3'd0, 8'h03); wr(3'd3, 8'h09); wr(3'd1, 8'h07);
    cyc(0, 3'd1, 0, 0, 1);
    cyc(0, 3'd1, 0, 0, 1);
    cyc(0, 3'd1, 0, 0, 1); chk("R6", {8'h0, rdata}, 16'h0007);
    cyc(0, 3'd1, 0, 0, 0); chk("R6", {8'h0, rdata}, 16'h0008);
    wr(3'd0, 8'h07); wr(3'd3, 8'h08);
    repeat (3) cyc(0, 3'd1, 0, 0, 1);
    repeat (3) cyc(0, 3'd1, 0, 0, 0);
    chk("R11", {8'h0, rdata}, 16'h0009);
    wr(3'd0, 8'h03); wr(3'd3, 8'h09);
    repeat (3) cyc(0, 3'd1, 0, 0, 1);
    repeat (3) cyc(0, 3'd1, 0, 0, 0);
    chk("R11", {8'h0, rdata}, 16'h0000);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic e;
      a = 3'($urandom % 8);
      e = (($urandom % 10) < 3) ? ~ext : ext;
      if (($urandom % 100) < 8) begin
        case (a)
          3'd0: d = 8'($urandom % 64) | 8'h01;
          3'd1: d = 8'($urandom);
          3'd2: d = (($urandom % 2) == 0) ? 8'h00 : 8'hFF;
          3'd3: d = 8'($urandom % 16);
          3'd4: d = 8'h00;
          3'd5: d = (($urandom % 2) == 0) ? 8'h0B : 8'($urandom % 16);
          default: d = 8'($urandom % 2);
        endcase
        cyc(1, a, d, 1'($urandom % 2), e);
      end else begin
        cyc(0, a, 8'h00, 1'($urandom % 2), e);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule